// File: doc/BRIEF.md
# Self-Timed Program Cycle Controller

This block sits behind the serial front end of a small non-volatile memory model and executes its program instructions. The front end hands over an already decoded request: one of four program operations, a target address, the data and the organisation (sixteen-bit words or eight-bit bytes). The controller holds that request and waits for the chip-select line to fall, then runs a programming cycle whose length is counted in system clocks and does not depend on the serial clock. The cycle length is a parameter that stands in for the real multi-millisecond delay.

The array is modelled as a bank of bytes that resets to all ones. A single word write first clears the word to ones halfway through the cycle and then loads the data at the end. A write to every word skips the erase, so each word ends as the bitwise AND of its old value and the data. While chip select is high after a cycle has been launched, the serial output shows the cycle state: 0 while busy, 1 when ready. The ready level stays until a new start bit is seen or chip select falls. A combinational read port lets the read path fetch a word or byte.

Top module: `pgm_cycle_ctl`

## Requirements
- R1: An accepted request starts a cycle only on the first clock where chip select is seen low after being seen high; without a pending request a falling chip select starts nothing.
- R2: Once started, `busy` stays high for exactly TWP_CYCLES clocks, and `done` pulses for the single clock that follows.
- R3: Operation code 0 (single erase) sets the addressed word to all ones at the end of the cycle; code 2 (erase all) sets every byte to 8'hFF.
- R4: Operation code 1 (single write) sets the target word to all ones after TWP_CYCLES/2 clocks of the cycle, and the word holds the request data at the end.
- R5: Operation code 3 (write all) leaves every word as the AND of its old content and the data, with no erase step.
- R6: While a launched cycle's status is active and chip select is high, `qDrive` is 1 and `qOut` is 0 during busy and 1 once ready. Start bits during busy change nothing. After ready, a start bit or a falling chip select turns the status off.
- R7: A request that arrives while busy raises `reqReject` on the next clock, and it is never executed.
- R8: A serial clock rising edge between acceptance and the fall of chip select cancels the pending request.
- R9: After reset every byte reads 8'hFF, and `busy`, `done` and `qDrive` are 0.
- R10: In sixteen-bit mode (`orgWide`=1) the address uses bits [3:0], and word a is byte 2a (low half, data[7:0]) plus byte 2a+1 (high half, data[15:8]). In eight-bit mode the address uses bits [4:0] and the data uses bits [7:0]. `rdData` follows the live `orgWide`, and in eight-bit mode its upper byte reads as zero.
- R11: Serial clock edges during a running cycle do not change its length or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sLevel | input | 1 | Chip select level |
| sclkRise | input | 1 | One-clock pulse per serial clock rising edge |
| startBit | input | 1 | One-clock pulse when the decoder sees a start bit |
| orgWide | input | 1 | 1 = sixteen-bit words, 0 = bytes |
| reqValid | input | 1 | Decoded program request present |
| reqOp | input | 2 | 0 erase, 1 write, 2 erase all, 3 write all |
| reqAddr | input | 5 | Target address |
| reqData | input | 16 | Program data |
| rdAddr | input | 5 | Read port address |
| rdData | output | 16 | Read port data |
| qOut | output | 1 | Status level on the serial output |
| qDrive | output | 1 | Serial output is being driven with status |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-clock pulse at end of cycle |
| reqReject | output | 1 | Request refused because busy |

## Verification
Directed writes in both organisations separate the byte-lane and address mapping. A write-all that follows a single write shows whether an erase was wrongly added, because only the AND result keeps zeros from both values. The midpoint probe on a word write tells a real erase phase apart from a single load at the end. Cancel, reject and start-bit-during-busy cases each show whether the block ignores the extra stimulus. A random mix of operations, organisations and serial clock noise is checked against a byte-level model after every cycle.

// File: rtl/pgm_cycle_pkg.sv
package pgm_cycle_pkg;

  typedef enum logic [1:0] {
    OP_ERASE     = 2'd0,
    OP_WRITE     = 2'd1,
    OP_ERASE_ALL = 2'd2,
    OP_WRITE_ALL = 2'd3
  } pgmOp_e;

  // Strobes from control to the array datapath
  typedef struct packed {
    logic capture;    // latch address, data and organisation
    logic clearWord;  // addressed word to all ones
    logic loadWord;   // addressed word takes the data
    logic setAll;     // whole array to all ones
    logic maskAll;    // every word ANDed with the data
  } pgmStrobe_t;

endpackage

// File: rtl/pgm_cycle_fsm.sv
module pgm_cycle_fsm
  import pgm_cycle_pkg::*;
#(
  parameter int TWP_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sLevel,
  input  logic       sclkRise,
  input  logic       startBit,
  input  logic       reqValid,
  input  pgmOp_e     reqOp,
  output logic       busy,
  output logic       done,
  output logic       reqReject,
  output logic       statusOn,
  output pgmStrobe_t strobe
);

  localparam int CNT_W     = $clog2(TWP_CYCLES + 1);
  localparam int ERASE_END = TWP_CYCLES / 2;

  logic             sPrev;
  logic             pending;
  pgmOp_e           opQ;
  logic             busyQ;
  logic [CNT_W-1:0] cnt;
  logic             statusQ;
  logic             doneQ;
  logic             rejQ;

  logic sFall;
  logic launch;
  logic lastTick;
  logic eraseTick;
  logic accept;

  assign sFall     = sPrev & ~sLevel;
  assign accept    = reqValid & ~busyQ;
  assign launch    = pending & sFall & ~busyQ;
  assign lastTick  = busyQ && (cnt == CNT_W'(TWP_CYCLES - 1));
  assign eraseTick = busyQ && (cnt == CNT_W'(ERASE_END - 1)) && (opQ == OP_WRITE);

  always_comb begin
    strobe           = '0;
    strobe.capture   = accept;
    strobe.clearWord = eraseTick | (lastTick & (opQ == OP_ERASE));
    strobe.loadWord  = lastTick & (opQ == OP_WRITE);
    strobe.setAll    = lastTick & (opQ == OP_ERASE_ALL);
    strobe.maskAll   = lastTick & (opQ == OP_WRITE_ALL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sPrev   <= 1'b0;
      pending <= 1'b0;
      opQ     <= OP_ERASE;
      busyQ   <= 1'b0;
      cnt     <= '0;
      statusQ <= 1'b0;
      doneQ   <= 1'b0;
      rejQ    <= 1'b0;
    end else begin
      sPrev <= sLevel;
      doneQ <= lastTick;
      rejQ  <= reqValid & busyQ;

      // pending request: capture, launch or cancel on a stray serial edge
      if (accept) begin
        pending <= 1'b1;
        opQ     <= reqOp;
      end else if (launch) begin
        pending <= 1'b0;
      end else if (pending && sclkRise) begin
        pending <= 1'b0;
      end

      // self-timed cycle counter
      if (launch) begin
        busyQ <= 1'b1;
        cnt   <= '0;
      end else if (lastTick) begin
        busyQ <= 1'b0;
        cnt   <= '0;
      end else if (busyQ) begin
        cnt <= cnt + 1'b1;
      end

      // status visibility on the serial output
      if (launch) begin
        statusQ <= 1'b1;
      end else if (statusQ && !busyQ && (sFall || startBit)) begin
        statusQ <= 1'b0;
      end
    end
  end

  assign busy      = busyQ;
  assign done      = doneQ;
  assign reqReject = rejQ;
  assign statusOn  = statusQ;

endmodule

// File: rtl/pgm_cycle_array.sv
module pgm_cycle_array
  import pgm_cycle_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  pgmStrobe_t                   strobe,
  input  logic                         orgWide,
  input  logic [$clog2(NUM_BYTES)-1:0] reqAddr,
  input  logic [2*BYTE_W-1:0]          reqData,
  input  logic [$clog2(NUM_BYTES)-1:0] rdAddr,
  output logic [2*BYTE_W-1:0]          rdData
);

  localparam int ADDR_W = $clog2(NUM_BYTES);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] memQ [NUM_BYTES];
  logic [ADDR_W-1:0] capAddr;
  logic [WORD_W-1:0] capData;
  logic              capWide;

  logic [NUM_BYTES-1:0] hit;
  logic [BYTE_W-1:0]    laneByte [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] BYTE_IDX = ADDR_W'(g);
    assign hit[g] = capWide ? (BYTE_IDX[ADDR_W-1:1] == capAddr[ADDR_W-2:0])
                            : (BYTE_IDX == capAddr);
    if (g % 2 == 1) begin : g_odd
      assign laneByte[g] = capWide ? capData[WORD_W-1:BYTE_W] : capData[BYTE_W-1:0];
    end else begin : g_even
      assign laneByte[g] = capData[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BYTES; i++) memQ[i] <= '1;
      capAddr <= '0;
      capData <= '0;
      capWide <= 1'b0;
    end else begin
      if (strobe.capture) begin
        capAddr <= reqAddr;
        capData <= reqData;
        capWide <= orgWide;
      end
      for (int i = 0; i < NUM_BYTES; i++) begin
        if (strobe.setAll) begin
          memQ[i] <= '1;
        end else if (strobe.maskAll) begin
          memQ[i] <= memQ[i] & laneByte[i];
        end else if (hit[i]) begin
          if (strobe.clearWord)     memQ[i] <= '1;
          else if (strobe.loadWord) memQ[i] <= laneByte[i];
        end
      end
    end
  end

  logic [ADDR_W-1:0] loIdx;
  logic [ADDR_W-1:0] hiIdx;

  assign loIdx = {rdAddr[ADDR_W-2:0], 1'b0};
  assign hiIdx = {rdAddr[ADDR_W-2:0], 1'b1};

  always_comb begin
    if (orgWide) rdData = {memQ[hiIdx], memQ[loIdx]};
    else         rdData = {{BYTE_W{1'b0}}, memQ[rdAddr]};
  end

endmodule

// File: rtl/pgm_cycle_ctl.sv
module pgm_cycle_ctl
  import pgm_cycle_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int NUM_BYTES  = 32,
  parameter int TWP_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sLevel,
  input  logic        sclkRise,
  input  logic        startBit,
  input  logic        orgWide,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [4:0]  reqAddr,
  input  logic [15:0] reqData,
  input  logic [4:0]  rdAddr,
  output logic [15:0] rdData,
  output logic        qOut,
  output logic        qDrive,
  output logic        busy,
  output logic        done,
  output logic        reqReject
);

  pgmStrobe_t strobeBus;
  logic       statusOn;

  pgm_cycle_fsm #(.TWP_CYCLES(TWP_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sLevel    (sLevel),
    .sclkRise  (sclkRise),
    .startBit  (startBit),
    .reqValid  (reqValid),
    .reqOp     (pgmOp_e'(reqOp)),
    .busy      (busy),
    .done      (done),
    .reqReject (reqReject),
    .statusOn  (statusOn),
    .strobe    (strobeBus)
  );

  pgm_cycle_array #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobeBus),
    .orgWide (orgWide),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .rdAddr  (rdAddr),
    .rdData  (rdData)
  );

  assign qDrive = sLevel & statusOn;
  assign qOut   = qDrive & ~busy;

endmodule

// File: rtl/pgm_cycle_chk.sv
module pgm_cycle_chk
  import pgm_cycle_pkg::*;
#(
  parameter int TWP_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sLevel,
  input logic       reqValid,
  input logic       busy,
  input logic       done,
  input logic       reqReject,
  input logic       qDrive,
  input pgmStrobe_t strobeBus
);

  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= '0;
  end

  // R1: a cycle begins only after chip select was seen low
  p_launch_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(sLevel));

  // R2: busy window length
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busyRun == 32'(TWP_CYCLES)));

  // R2: done follows the end of busy
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7: request during busy is refused next clock
  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && busy) |=> reqReject);

  // R6: status never driven with chip select low
  p_no_drive_s_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sLevel |-> !qDrive);

  // R3: at most one array update per clock
  p_one_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobeBus.clearWord, strobeBus.loadWord, strobeBus.setAll, strobeBus.maskAll}));

  // R2: array changes only while busy
  p_update_in_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobeBus.clearWord || strobeBus.loadWord || strobeBus.setAll || strobeBus.maskAll) |-> busy);

endmodule

bind pgm_cycle_ctl pgm_cycle_chk #(.TWP_CYCLES(TWP_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sLevel    (sLevel),
  .reqValid  (reqValid),
  .busy      (busy),
  .done      (done),
  .reqReject (reqReject),
  .qDrive    (qDrive),
  .strobeBus (strobeBus)
);

// File: tb/pgm_cycle_ctl_bench.sv
module pgm_cycle_ctl_bench;

  localparam int PERIOD = 10;
  localparam int TWP    = 16;
  localparam int HALF   = TWP / 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sLevel = 0, sclkRise = 0, startBit = 0, orgWide = 0, reqValid = 0;
  logic [1:0]  reqOp = 0;
  logic [4:0]  reqAddr = 0, rdAddr = 0;
  logic [15:0] reqData = 0;
  logic [15:0] rdData;
  logic        qOut, qDrive, busy, done, reqReject;

  int checks = 0;
  int failures = 0;
  logic [7:0] refMem [32];

  always #(PERIOD/2) clk = ~clk;

  pgm_cycle_ctl #(.TWP_CYCLES(TWP)) u_pgm_cycle_ctl (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void refApply(input int op, input logic [4:0] a, input logic [15:0] d, input bit wide);
    case (op)
      0: if (wide) begin refMem[{a[3:0],1'b0}] = 8'hFF; refMem[{a[3:0],1'b1}] = 8'hFF; end
         else refMem[a] = 8'hFF;
      1: if (wide) begin refMem[{a[3:0],1'b0}] = d[7:0]; refMem[{a[3:0],1'b1}] = d[15:8]; end
         else refMem[a] = d[7:0];
      2: for (int i = 0; i < 32; i++) refMem[i] = 8'hFF;
      default: for (int i = 0; i < 32; i++)
                 refMem[i] = refMem[i] & ((wide && i[0]) ? d[15:8] : d[7:0]);
    endcase
  endfunction

  function automatic logic [15:0] refWord(input logic [4:0] a, input bit wide);
    if (wide) return {refMem[{a[3:0],1'b1}], refMem[{a[3:0],1'b0}]};
    return {8'h00, refMem[a]};
  endfunction

  task automatic sweep(input string req);
    int bad = 0;
    logic [15:0] firstAct = 0, firstExp = 0;
    @(negedge clk);
    orgWide = 0;
    for (int a = 0; a < 32; a++) begin
      rdAddr = 5'(a);
      #1;
      if (rdData !== refWord(5'(a), 0)) begin
        if (bad == 0) begin firstAct = rdData; firstExp = refWord(5'(a), 0); end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
  endtask

  task automatic issueReq(input int op, input logic [4:0] a, input logic [15:0] d, input bit wide);
    @(negedge clk);
    sLevel = 1; orgWide = wide; reqValid = 1; reqOp = 2'(op); reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 0;
  endtask

  // drop S, run the cycle and check timing and status
  task automatic runCycle(input bit holdS, input bit midChk, input bit startMid,
                          input bit clearByStart, input bit noisy, input logic [15:0] oldWord);
    int k = 0;
    bit statusOk = 1;
    @(negedge clk);
    sLevel = 0;
    forever begin
      @(negedge clk);
      startBit = 0;
      sclkRise = noisy ? 1'($urandom % 2) : 1'b0;
      if (k == 0 && holdS) sLevel = 1;
      if (k == 2 && startMid) startBit = 1;
      #1;
      if (!busy) break;
      if (holdS && !(qDrive === 1'b1 && qOut === 1'b0)) statusOk = 0;
      if (midChk && k == HALF - 1) check(rdData === oldWord, "R4 before erase", rdData, oldWord);
      if (midChk && k == HALF)
        check(rdData === (orgWide ? 16'hFFFF : 16'h00FF), "R4 erase phase", rdData,
              orgWide ? 16'hFFFF : 16'h00FF);
      k++;
      if (k > 4 * TWP) break;
    end
    sclkRise = 0;
    startBit = 0;
    check(k == TWP, "R2 busy length", 32'(k), 32'(TWP));
    check(done === 1'b1, "R2 done pulse", 32'(done), 1);
    if (holdS) begin
      check(statusOk, "R6 busy status", 32'(statusOk), 1);
      check(qDrive === 1'b1 && qOut === 1'b1, "R6 ready status", {qDrive, qOut}, 2'b11);
      if (clearByStart) begin
        @(negedge clk); startBit = 1;
        @(negedge clk); startBit = 0; #1;
        check(qDrive === 1'b0, "R6 start bit clears ready", 32'(qDrive), 0);
        @(negedge clk); sLevel = 0;
      end else begin
        @(negedge clk); sLevel = 0;
        @(negedge clk); sLevel = 1;
        @(negedge clk); #1;
        check(qDrive === 1'b0, "R6 S fall clears ready", 32'(qDrive), 0);
        sLevel = 0;
      end
    end else begin
      @(negedge clk); #1;
      check(done === 1'b0, "R2 done one clock", 32'(done), 0);
    end
  endtask

  task automatic doOp(input int op, input logic [4:0] a, input logic [15:0] d, input bit wide,
                      input bit holdS, input bit midChk, input bit noisy, input string req);
    logic [15:0] oldWord;
    oldWord = refWord(a, wide);
    rdAddr = a;
    issueReq(op, a, d, wide);
    runCycle(holdS, midChk, 1'b0, 1'b0, noisy, oldWord);
    refApply(op, a, d, wide);
    if (wide) begin
      @(negedge clk); orgWide = 1; rdAddr = a; #1;
      check(rdData === refWord(a, 1), {req, " word read"}, rdData, refWord(a, 1));
    end
    sweep(req);
  endtask

  initial begin
    repeat (1500 * 100) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) refMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R9 reset state
    check(busy === 0 && done === 0 && qDrive === 0, "R9 reset outputs", {busy, done, qDrive}, 0);
    sweep("R9 reset array");

    // R4 R10 sixteen-bit write with midpoint probe and status
    doOp(1, 5'd3, 16'hA55A, 1, 1, 1, 0, "R4 R10 write x16");
    // R4 R10 byte write
    doOp(1, 5'd17, 16'hBE3C, 0, 0, 1, 0, "R4 R10 write x8");
    // R5 write all in wide mode, no erase
    doOp(3, 5'd0, 16'hF0F0, 1, 1, 0, 0, "R5 write all");
    // R3 single erase in byte mode
    doOp(0, 5'd6, 16'h0000, 0, 0, 0, 0, "R3 erase x8");
    doOp(0, 5'd3, 16'h0000, 1, 0, 0, 0, "R3 erase x16");

    // R6 start bit during busy is ignored, ready cleared by start bit
    begin
      logic [15:0] ow;
      ow = refWord(5'd12, 0);
      rdAddr = 5'd12;
      issueReq(1, 5'd12, 16'h0055, 0);
      runCycle(1, 0, 1, 1, 0, ow);
      refApply(1, 5'd12, 16'h0055, 0);
      sweep("R6 start bit during busy");
    end

    // R7 request while busy is rejected
    issueReq(1, 5'd9, 16'h0011, 0);
    @(negedge clk); sLevel = 0;
    @(negedge clk);
    reqValid = 1; reqOp = 2'd1; reqAddr = 5'd10; reqData = 16'h0022;
    @(negedge clk);
    reqValid = 0; #1;
    check(reqReject === 1'b1, "R7 reject pulse", 32'(reqReject), 1);
    for (int n = 0; n < 4 * TWP && busy; n++) @(negedge clk);
    refApply(1, 5'd9, 16'h0011, 0);
    @(negedge clk); sLevel = 1;
    @(negedge clk); sLevel = 0;
    repeat (3) @(negedge clk); #1;
    check(busy === 1'b0, "R7 rejected request not run", 32'(busy), 0);
    sweep("R7 array after reject");

    // R8 stray serial clock cancels the pending request
    issueReq(2, 5'd0, 16'h0000, 0);
    @(negedge clk); sclkRise = 1;
    @(negedge clk); sclkRise = 0; sLevel = 0;
    repeat (3) @(negedge clk); #1;
    check(busy === 1'b0, "R8 cancel by serial clock", 32'(busy), 0);
    // R1 S fall with nothing pending starts nothing
    @(negedge clk); sLevel = 1;
    @(negedge clk); sLevel = 0;
    repeat (2) @(negedge clk); #1;
    check(busy === 1'b0, "R1 no launch without request", 32'(busy), 0);
    sweep("R8 array after cancel");

    // R3 erase all
    doOp(2, 5'd0, 16'h0000, 0, 1, 0, 0, "R3 erase all");

    // random mix, R11 serial clock noise during cycles
    for (int n = 0; n < 30; n++) begin
      int op;
      bit wide;
      op   = int'($urandom % 4);
      wide = 1'($urandom % 2);
      doOp(op, 5'($urandom), 16'($urandom), wide, 1'($urandom % 2), 0, 1, "R11 random op");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule